// File: doc/BRIEF.md
# DSP Program Sequencer with Hardware Loops

This block computes the program counter of a 16-bit-instruction DSP. Each cycle it may be handed one decoded instruction (an operation kind, the first opcode word, the optional second word, and a condition-true bit from the flag logic). It works out the next PC from that instruction and runs its four small hardware stacks. The call stack holds return addresses and the loop start address. The status stack holds the saved status word. The loop-end stack and the loop-count stack carry the state of zero-overhead block loops.

The PC register always holds the address of the instruction now being issued. The block reads the register file through a combinational port, whose index it selects from the opcode. It asks the fetch side for the word count of the instruction at a given address, which it needs for conditional skips and for skipping a loop body. An interrupt request takes priority over an issued instruction. A halt freezes the sequencer until reset.

Top module: `dsp_pc_sequencer`

## Requirements
- R1: After reset, `pc_o` is 0, and `halt_o`, `exc_busy_o`, `loop_active_o`, `sr_load_o` and `stk_err_o` are all zero.
- R2: Operation kinds are coded NOP=0, JCC=1, JRCC=2, CALL=3, CALLR=4, RET=5, RTI=6, HALT=7, IFCC=8, BLOOP=9, BLOOPI=10; any other code acts as NOP. JCC, CALL, BLOOP and BLOOPI occupy two words and all others one word. An issued instruction that transfers no control advances `pc_o` by its word count.
- R3: The condition selector is `opcode_i[3:0]`. The value 0xF means always; any other value uses `cond_true_i`. A taken JCC loads the second word into the PC. A taken JRCC loads the register whose index is `opcode_i[7:5]`, and `rf_idx_o` then reads `{2'b00, opcode_i[7:5]}`.
- R4: A taken CALL or CALLR pushes the address after itself onto the call stack and jumps (CALL to the second word, CALLR to the register at `opcode_i[7:5]`). A taken RET pops the call stack into the PC. When the condition fails, none of them changes a stack.
- R5: RTI, regardless of the condition, pops the PC from the call stack and the status word from the status stack. In its issue cycle `sr_load_o` is high with `sr_val_o` equal to the popped status. `exc_busy_o` is low from the next cycle.
- R6: `irq_take_i` wins over an issued instruction in the same cycle. It pushes the current PC onto the call stack and `sr_i` onto the status stack, loads `IRQ_VEC` (default 0x0100) into the PC, and sets `exc_busy_o`.
- R7: HALT sets `halt_o` and keeps the PC at the halt's own address. Once halted, issued instructions and interrupts have no effect on `pc_o` or `exc_busy_o` until reset.
- R8: An IFCC whose condition fails drives `size_addr_o` = PC+1 and sets the PC to PC+1+`size_i`. When the condition holds, it is a one-word step.
- R9: BLOOP takes its count from the register at `opcode_i[4:0]` (`rf_idx_o` = `opcode_i[4:0]`). BLOOPI takes it from `opcode_i[7:0]`, zero-extended. A nonzero count pushes PC+2 onto the call stack, the second word (the loop end address) onto the loop-end stack and the count onto the count stack, and raises `loop_active_o`.
- R10: A block loop with count zero drives `size_addr_o` = second word, sets the PC to that address plus `size_i`, and pushes nothing.
- R11: When an instruction at the address on top of the loop-end stack issues without a control transfer, the top count drops by one. A nonzero result sends the PC to the top of the call stack. A zero result pops the call, loop-end and count stacks and steps normally. The body therefore runs count times.
- R12: A control transfer taken by the instruction at the loop end address wins over the loop step: the PC follows the transfer and the loop count is left unchanged.
- R13: Each stack holds `STK_DEPTH` (default 4) entries. A push when full is dropped and a pop when empty is ignored. Either case sets that stack's sticky bit in `stk_err_o` (bit 0 call, 1 status, 2 loop end, 3 count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_kind_i | input | 4 | Decoded operation kind |
| opcode_i | input | 16 | First instruction word |
| ext_word_i | input | 16 | Second instruction word (target or loop end) |
| cond_true_i | input | 1 | Selected condition is true, from flag logic |
| rf_idx_o | output | 5 | Register file read index |
| rf_data_i | input | 16 | Register file read data |
| size_addr_o | output | 16 | Address whose instruction size is requested |
| size_i | input | 2 | Word count of the instruction at `size_addr_o` |
| irq_take_i | input | 1 | Enter the interrupt handler this cycle |
| sr_i | input | 16 | Current status word, saved on interrupt entry |
| pc_o | output | 16 | Program counter |
| halt_o | output | 1 | Halted |
| exc_busy_o | output | 1 | Exception handler in progress |
| sr_load_o | output | 1 | Status restore strobe (RTI) |
| sr_val_o | output | 16 | Status value to restore |
| loop_active_o | output | 1 | At least one block loop is live |
| stk_err_o | output | 4 | Sticky stack overflow/underflow flags |

## Verification
Two functions can fall in the same cycle. The first pair is the loop-end step and a control transfer taken by the instruction at the loop end address. The bench provokes this by issuing a taken jump from the end address back into the body. It then counts how many more passes the loop makes before it exits, which shows whether the counter moved. The second pair is an interrupt and an issued taken jump in the same cycle. That case is judged by the PC reaching the vector and by the status value that the following return-from-interrupt hands back.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;

  typedef enum logic [3:0] {
    K_NOP    = 4'd0,
    K_JCC    = 4'd1,
    K_JRCC   = 4'd2,
    K_CALL   = 4'd3,
    K_CALLR  = 4'd4,
    K_RET    = 4'd5,
    K_RTI    = 4'd6,
    K_HALT   = 4'd7,
    K_IFCC   = 4'd8,
    K_BLOOP  = 4'd9,
    K_BLOOPI = 4'd10
  } op_kind_e;

  localparam logic [3:0] COND_ALWAYS = 4'hF;

  localparam int NUM_STK  = 4;
  localparam int STK_CALL = 0;
  localparam int STK_STAT = 1;
  localparam int STK_LEND = 2;
  localparam int STK_LCNT = 3;

  typedef struct packed {
    logic push;
    logic pop;
    logic upd;   // overwrite top in place
  } stk_ctl_t;

endpackage

// File: rtl/seq_hw_stack.sv
module seq_hw_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  dsp_seq_pkg::stk_ctl_t        ctl_i,
  input  logic [W-1:0]                 din_i,
  output logic [W-1:0]                 top_o,
  output logic [$clog2(DEPTH+1)-1:0]   lvl_o,
  output logic                         err_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [LW-1:0] lvl_q;
  logic [LW-1:0] lvl_m1;
  logic          err_q;

  assign lvl_m1 = lvl_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (ctl_i.push) begin
      if (lvl_q == FULL) begin
        err_q <= 1'b1;
      end else begin
        mem_q[lvl_q[AW-1:0]] <= din_i;
        lvl_q                <= lvl_q + 1'b1;
      end
    end else if (ctl_i.pop) begin
      if (lvl_q == '0) err_q <= 1'b1;
      else             lvl_q <= lvl_m1;
    end else if (ctl_i.upd && lvl_q != '0) begin
      mem_q[lvl_m1[AW-1:0]] <= din_i;
    end
  end

  assign top_o = (lvl_q == '0) ? '0 : mem_q[lvl_m1[AW-1:0]];
  assign lvl_o = lvl_q;
  assign err_o = err_q;

  p_one_op_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_i.push && ctl_i.pop));
  p_lvl_bound_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= FULL);
  p_err_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_full_push_keeps_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.push && lvl_q == FULL) |=> (lvl_q == FULL) && err_q);

endmodule

// File: rtl/seq_next_pc.sv
module seq_next_pc
  import dsp_seq_pkg::*;
#(
  parameter int          W       = 16,
  parameter logic [15:0] IRQ_VEC = 16'h0100
) (
  input  logic                          halted_i,
  input  logic                          irq_i,
  input  logic                          issue_i,
  input  logic [3:0]                    kind_i,
  input  logic [15:0]                   opcode_i,
  input  logic [W-1:0]                  ext_i,
  input  logic                          cond_true_i,
  input  logic [W-1:0]                  pc_i,
  input  logic [W-1:0]                  rf_data_i,
  input  logic [1:0]                    size_i,
  input  logic [W-1:0]                  sr_i,
  input  logic [W-1:0]                  call_top_i,
  input  logic [W-1:0]                  lend_top_i,
  input  logic [W-1:0]                  lcnt_top_i,
  input  logic                          loop_live_i,
  output logic [4:0]                    rf_idx_o,
  output logic [W-1:0]                  size_addr_o,
  output logic [W-1:0]                  next_pc_o,
  output stk_ctl_t [NUM_STK-1:0]        ctl_o,
  output logic [NUM_STK-1:0][W-1:0]     din_o,
  output logic                          halt_set_o,
  output logic                          exc_set_o,
  output logic                          exc_clr_o,
  output logic                          sr_load_o
);
  op_kind_e     k;
  logic         two_word;
  logic         cond_ok;
  logic [W-1:0] seq_pc;
  logic [W-1:0] loop_cnt;
  logic         xfer;

  assign k        = op_kind_e'(kind_i);
  assign two_word = k inside {K_JCC, K_CALL, K_BLOOP, K_BLOOPI};
  assign seq_pc   = pc_i + (two_word ? W'(2) : W'(1));
  assign cond_ok  = (opcode_i[3:0] == COND_ALWAYS) || cond_true_i;
  assign loop_cnt = (k == K_BLOOPI) ? W'(opcode_i[7:0]) : rf_data_i;

  assign rf_idx_o    = (k inside {K_JRCC, K_CALLR}) ? {2'b00, opcode_i[7:5]} : opcode_i[4:0];
  assign size_addr_o = (k == K_IFCC) ? pc_i + W'(1) : ext_i;

  always_comb begin
    next_pc_o  = pc_i;
    ctl_o      = '0;
    din_o      = '0;
    halt_set_o = 1'b0;
    exc_set_o  = 1'b0;
    exc_clr_o  = 1'b0;
    sr_load_o  = 1'b0;
    xfer       = 1'b0;
    if (!halted_i) begin
      if (irq_i) begin
        ctl_o[STK_CALL].push = 1'b1;
        din_o[STK_CALL]      = pc_i;
        ctl_o[STK_STAT].push = 1'b1;
        din_o[STK_STAT]      = sr_i;
        next_pc_o            = W'(IRQ_VEC);
        exc_set_o            = 1'b1;
      end else if (issue_i) begin
        next_pc_o = seq_pc;
        case (k)
          K_JCC: if (cond_ok) begin
            next_pc_o = ext_i;
            xfer      = 1'b1;
          end
          K_JRCC: if (cond_ok) begin
            next_pc_o = rf_data_i;
            xfer      = 1'b1;
          end
          K_CALL, K_CALLR: if (cond_ok) begin
            ctl_o[STK_CALL].push = 1'b1;
            din_o[STK_CALL]      = seq_pc;
            next_pc_o            = (k == K_CALL) ? ext_i : rf_data_i;
            xfer                 = 1'b1;
          end
          K_RET: if (cond_ok) begin
            ctl_o[STK_CALL].pop = 1'b1;
            next_pc_o           = call_top_i;
            xfer                = 1'b1;
          end
          K_RTI: begin
            ctl_o[STK_CALL].pop = 1'b1;
            ctl_o[STK_STAT].pop = 1'b1;
            next_pc_o           = call_top_i;
            sr_load_o           = 1'b1;
            exc_clr_o           = 1'b1;
            xfer                = 1'b1;
          end
          K_HALT: begin
            next_pc_o  = pc_i;
            halt_set_o = 1'b1;
            xfer       = 1'b1;
          end
          K_IFCC: if (!cond_ok) begin
            next_pc_o = pc_i + W'(1) + W'(size_i);
            xfer      = 1'b1;
          end
          K_BLOOP, K_BLOOPI: begin
            xfer = 1'b1;
            if (loop_cnt != '0) begin
              ctl_o[STK_CALL].push = 1'b1;
              din_o[STK_CALL]      = seq_pc;
              ctl_o[STK_LEND].push = 1'b1;
              din_o[STK_LEND]      = ext_i;
              ctl_o[STK_LCNT].push = 1'b1;
              din_o[STK_LCNT]      = loop_cnt;
            end else begin
              next_pc_o = ext_i + W'(size_i);
            end
          end
          default: ;
        endcase
        // loop step only when the end instruction did not redirect
        if (!xfer && loop_live_i && pc_i == lend_top_i) begin
          if (lcnt_top_i <= W'(1)) begin
            ctl_o[STK_CALL].pop = 1'b1;
            ctl_o[STK_LEND].pop = 1'b1;
            ctl_o[STK_LCNT].pop = 1'b1;
            next_pc_o           = seq_pc;
          end else begin
            ctl_o[STK_LCNT].upd = 1'b1;
            din_o[STK_LCNT]     = lcnt_top_i - W'(1);
            next_pc_o           = call_top_i;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dsp_pc_sequencer.sv
module dsp_pc_sequencer
  import dsp_seq_pkg::*;
#(
  parameter int          W         = 16,
  parameter int          STK_DEPTH = 4,
  parameter logic [15:0] RESET_PC  = 16'h0000,
  parameter logic [15:0] IRQ_VEC   = 16'h0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [3:0]    op_kind_i,
  input  logic [15:0]   opcode_i,
  input  logic [W-1:0]  ext_word_i,
  input  logic          cond_true_i,
  output logic [4:0]    rf_idx_o,
  input  logic [W-1:0]  rf_data_i,
  output logic [W-1:0]  size_addr_o,
  input  logic [1:0]    size_i,
  input  logic          irq_take_i,
  input  logic [W-1:0]  sr_i,
  output logic [W-1:0]  pc_o,
  output logic          halt_o,
  output logic          exc_busy_o,
  output logic          sr_load_o,
  output logic [W-1:0]  sr_val_o,
  output logic          loop_active_o,
  output logic [3:0]    stk_err_o
);
  localparam int LW = $clog2(STK_DEPTH + 1);

  logic [W-1:0]                 pc_q, pc_d;
  logic                         halt_q, exc_q;
  logic                         halt_set, exc_set, exc_clr;
  stk_ctl_t [NUM_STK-1:0]       stk_ctl;
  logic [NUM_STK-1:0][W-1:0]    stk_din;
  logic [W-1:0]                 stk_top [NUM_STK];
  logic [LW-1:0]                stk_lvl [NUM_STK];
  logic [NUM_STK-1:0]           stk_err;

  for (genvar g = 0; g < NUM_STK; g++) begin : g_stk
    seq_hw_stack #(.W(W), .DEPTH(STK_DEPTH)) u_stk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctl_i  (stk_ctl[g]),
      .din_i  (stk_din[g]),
      .top_o  (stk_top[g]),
      .lvl_o  (stk_lvl[g]),
      .err_o  (stk_err[g])
    );
  end

  seq_next_pc #(.W(W), .IRQ_VEC(IRQ_VEC)) u_next (
    .halted_i    (halt_q),
    .irq_i       (irq_take_i),
    .issue_i     (issue_i),
    .kind_i      (op_kind_i),
    .opcode_i    (opcode_i),
    .ext_i       (ext_word_i),
    .cond_true_i (cond_true_i),
    .pc_i        (pc_q),
    .rf_data_i   (rf_data_i),
    .size_i      (size_i),
    .sr_i        (sr_i),
    .call_top_i  (stk_top[STK_CALL]),
    .lend_top_i  (stk_top[STK_LEND]),
    .lcnt_top_i  (stk_top[STK_LCNT]),
    .loop_live_i (stk_lvl[STK_LEND] != '0),
    .rf_idx_o    (rf_idx_o),
    .size_addr_o (size_addr_o),
    .next_pc_o   (pc_d),
    .ctl_o       (stk_ctl),
    .din_o       (stk_din),
    .halt_set_o  (halt_set),
    .exc_set_o   (exc_set),
    .exc_clr_o   (exc_clr),
    .sr_load_o   (sr_load_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= W'(RESET_PC);
      halt_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (halt_set) halt_q <= 1'b1;
      if (exc_set)      exc_q <= 1'b1;
      else if (exc_clr) exc_q <= 1'b0;
    end
  end

  assign pc_o          = pc_q;
  assign halt_o        = halt_q;
  assign exc_busy_o    = exc_q;
  assign sr_val_o      = stk_top[STK_STAT];
  assign loop_active_o = stk_lvl[STK_LEND] != '0;
  assign stk_err_o     = stk_err;

  p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && (pc_o == $past(pc_o)));
  p_jcc_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !irq_take_i && !halt_o && op_kind_i == 4'd1 && opcode_i[3:0] == 4'hF)
      |=> pc_o == $past(ext_word_i));
  p_irq_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && !halt_o) |=> (pc_o == W'(IRQ_VEC)) && exc_busy_o);
  p_rti_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_o |=> !exc_busy_o);
  p_loop_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_lvl[STK_LEND] == stk_lvl[STK_LCNT]);

endmodule

// File: tb/sim_dsp_pc_sequencer.sv
module sim_dsp_pc_sequencer;
  localparam logic [3:0] NOP = 4'd0, JCC = 4'd1, JRCC = 4'd2, CALL = 4'd3, CALLR = 4'd4,
                         RET = 4'd5, RTI = 4'd6, HALT = 4'd7, IFCC = 4'd8,
                         BLOOP = 4'd9, BLOOPI = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  kind = '0;
  logic [15:0] opc = '0;
  logic [15:0] ext = '0;
  logic        ct = 1'b0;
  logic [4:0]  rf_idx;
  logic [15:0] rf_data;
  logic [15:0] size_addr;
  logic [1:0]  size;
  logic        irq = 1'b0;
  logic [15:0] sr = '0;
  logic [15:0] pc;
  logic        halt, exc_busy, sr_load, loop_act;
  logic [15:0] sr_val;
  logic [3:0]  stk_err;
  logic [15:0] rf [32];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign rf_data = rf[rf_idx];
  assign size    = size_addr[0] ? 2'd2 : 2'd1;  // odd addresses hold 2-word instructions

  dsp_pc_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_kind_i(kind), .opcode_i(opc),
    .ext_word_i(ext), .cond_true_i(ct), .rf_idx_o(rf_idx), .rf_data_i(rf_data),
    .size_addr_o(size_addr), .size_i(size), .irq_take_i(irq), .sr_i(sr), .pc_o(pc),
    .halt_o(halt), .exc_busy_o(exc_busy), .sr_load_o(sr_load), .sr_val_o(sr_val),
    .loop_active_o(loop_act), .stk_err_o(stk_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] k, input logic [15:0] o, input logic [15:0] e, input logic c);
    kind = k; opc = o; ext = e; ct = c; issue = 1'b1;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    #1;
  endtask

  task automatic step(input logic [3:0] k, input logic [15:0] o, input logic [15:0] e,
                      input logic c, input logic [15:0] exp_pc, input string tag);
    drive(k, o, e, c);
    commit();
    chk(tag, pc, exp_pc);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 0);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 16'(i * 16'h0101);
    rf[3] = 16'h0080;
    rf[5] = 16'h0300;
    rf[7] = 16'h0000;
    repeat (2) @(posedge clk);
    #1;
    // R1
    chk("R1 pc", pc, 16'h0000);
    chk("R1 flags", {halt, exc_busy, loop_act, sr_load, stk_err}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 sequencing
    step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0001, "R2 nop step");
    step(JCC, 16'h0003, 16'h0040, 1'b0, 16'h0003, "R2 untaken jcc is two words");
    step(4'd13, 16'h0000, 16'h0000, 1'b0, 16'h0004, "R2 unknown kind acts as nop");
    // R3
    step(JCC, 16'h000F, 16'h0040, 1'b0, 16'h0040, "R3 jcc always");
    drive(JRCC, 16'h0062, 16'h0000, 1'b1);
    chk("R3 jrcc reg index", rf_idx, 5'd3);
    commit();
    chk("R3 jrcc target", pc, 16'h0080);
    // R4
    step(CALL, 16'h000F, 16'h0200, 1'b0, 16'h0200, "R4 call");
    step(CALLR, 16'h00AF, 16'h0000, 1'b0, 16'h0300, "R4 callr");
    step(RET, 16'h0001, 16'h0000, 1'b0, 16'h0301, "R4 ret not taken");
    drive(NOP, 16'h0000, 16'h0000, 1'b0);
    commit();
    step(RET, 16'h000F, 16'h0000, 1'b0, 16'h0201, "R4 ret to callr+1");
    step(RET, 16'h0002, 16'h0000, 1'b1, 16'h0082, "R4 ret to call+2");
    // R8
    drive(IFCC, 16'h0004, 16'h0000, 1'b0);
    chk("R8 size query", size_addr, 16'h0083);
    commit();
    chk("R8 skip", pc, 16'h0082 + 16'd1 + 16'd2);
    step(IFCC, 16'h000F, 16'h0000, 1'b0, 16'h0086, "R8 pass");
    // R9 / R11: three passes over 0x88..0x8A
    step(BLOOPI, 16'h0003, 16'h008A, 1'b0, 16'h0088, "R9 bloopi start");
    chk("R9 loop active", loop_act, 1'b1);
    for (int it = 1; it <= 3; it++) begin
      step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0089, "R11 body");
      step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h008A, "R11 body");
      step(NOP, 16'h0000, 16'h0000, 1'b0, (it < 3) ? 16'h0088 : 16'h008B, "R11 loop end");
    end
    chk("R11 loop retired", loop_act, 1'b0);
    // R10
    drive(BLOOP, 16'h0007, 16'h0090, 1'b0);
    chk("R10 count register index", rf_idx, 5'd7);
    chk("R10 size query", size_addr, 16'h0090);
    commit();
    chk("R10 skip body", pc, 16'h0091);
    chk("R10 no push", loop_act, 1'b0);
    // R12: taken jump at loop end must not consume a pass
    step(BLOOPI, 16'h0002, 16'h0094, 1'b0, 16'h0093, "R12 start");
    step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0094, "R12 body");
    step(JCC, 16'h000F, 16'h0093, 1'b0, 16'h0093, "R12 jump wins");
    step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0094, "R12 body");
    step(JCC, 16'h0001, 16'h0050, 1'b0, 16'h0093, "R12 first real pass");
    step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0094, "R12 body");
    step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0095, "R12 exit after count");
    chk("R12 loop retired", loop_act, 1'b0);
    // R6 / R5
    irq = 1'b1; sr = 16'h1234;
    step(JCC, 16'h000F, 16'h0050, 1'b0, 16'h0100, "R6 irq beats jump");
    irq = 1'b0; sr = 16'h0000;
    chk("R6 exc busy", exc_busy, 1'b1);
    drive(RTI, 16'h000F, 16'h0000, 1'b0);
    chk("R5 sr strobe", sr_load, 1'b1);
    chk("R5 sr value", sr_val, 16'h1234);
    commit();
    chk("R5 pc", pc, 16'h0095);
    chk("R5 exc clear", exc_busy, 1'b0);
    // R13
    for (int i = 0; i < 4; i++) step(CALL, 16'h000F, 16'h0095, 1'b0, 16'h0095, "R13 fill");
    chk("R13 no error at depth", stk_err, 4'b0000);
    step(CALL, 16'h000F, 16'h0095, 1'b0, 16'h0095, "R13 overflow call");
    chk("R13 overflow flag", stk_err, 4'b0001);
    for (int i = 0; i < 4; i++) step(RET, 16'h000F, 16'h0000, 1'b0, 16'h0097, "R13 drain");
    step(RTI, 16'h000F, 16'h0000, 1'b0, 16'h0000, "R13 rti on empty");
    chk("R13 underflow flags", stk_err, 4'b0011);
    step(JCC, 16'h000F, 16'h0097, 1'b0, 16'h0097, "R13 reposition");
    // R7
    step(HALT, 16'h0000, 16'h0000, 1'b0, 16'h0097, "R7 halt pc");
    chk("R7 halt flag", halt, 1'b1);
    step(JCC, 16'h000F, 16'h0010, 1'b0, 16'h0097, "R7 jump ignored");
    irq = 1'b1;
    step(NOP, 16'h0000, 16'h0000, 1'b0, 16'h0097, "R7 irq ignored");
    irq = 1'b0;
    chk("R7 no exception", exc_busy, 1'b0);
    issue = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule